// File: doc/BRIEF.md
# Interrupt Collector

This block gathers up to 32 level-type interrupt inputs into one request line for a parent interrupt controller. Each input passes through a two-stage synchronizer and then sets a sticky pending bit. Software can hide any input with a mask bit, and it acknowledges an input by holding its clear bit at 1 for a while and then writing it back to 0. The block itself does no priority encoding. Software reads a status word and services the set bits from the lowest index upward.

Three word registers sit on a simple 32-bit bus with separate write and read strobes. A clear register holds the acknowledge bits. A mask register holds the hide bits. A read-only status register reports the pending bits that are not masked. Reads return data one cycle after the strobe. The parent line is the registered OR of the status word.

Top module: `irq_collector`

## Requirements
- R1: After the synchronous reset `rst` the mask register reads 0xFFFFFFFF, the clear register reads 0, the status register reads 0 and `irq_o` is low.
- R2: A source input that is high on a single clock edge sets its pending bit. The bit stays set after the input falls, and stays set until its clear bit is 1.
- R3: The mask register at byte offset 0x14 reads back the last value written. A mask bit of 1 removes its source from the status word and from `irq_o`, but it does not discard the pending bit.
- R4: The clear register at byte offset 0x10 reads back the last value written. While a clear bit is 1, its pending bit is 0 from the next clock onward, even if the source is high.
- R5: When a clear bit returns to 0 and its source is still high, the pending bit is set again on the following clock.
- R6: The status register at byte offset 0x1C reads as the bitwise AND of the pending bits and the inverted mask. Bit n belongs to source n, so bit 0 and bit 31 are reported independently.
- R7: `irq_o` is high on the clock after any status bit is set, and low on the clock after the status word is zero.
- R8: Reads from any other byte offset return 0, and writes to them change no register.
- R9: A read strobe that is sampled on a clock edge makes `rvalid_o` high for exactly the next cycle, with the data in `rdata_o`. `rdata_o` is 0 whenever `rvalid_o` is low.
- R10: With its mask bit at 0, a source that is first sampled high on clock edge k drives `irq_o` high after edge k+3 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous level interrupt sources, bit n is source n |
| wr_en_i | input | 1 | Write strobe for the register at `addr_i` |
| rd_en_i | input | 1 | Read strobe for the register at `addr_i` |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while `rvalid_o` is high |
| rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
The bench builds the block with its default parameters: 32 sources and a two-stage synchronizer. With those values the highest source bit 31 and the lowest bit 0 are both reachable, and the three-edge path from a source to `irq_o` can be counted exactly. The bench model delays the sources with a queue that is as deep as the synchronizer, so the cycle in which a pending bit appears, vanishes under a held clear, or comes back after the clear is released is predicted independently of the design. Directed sequences also check that a masked pending bit is kept and later shown, and that accesses to unmapped offsets have no effect.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    // Byte offsets that software decodes
    localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_HIDE   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h1C;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ACK,
        SEL_HIDE,
        SEL_STATUS
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_op_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_ACK:    s = SEL_ACK;
            OFS_HIDE:   s = SEL_HIDE;
            OFS_STATUS: s = SEL_STATUS;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < int'(STAGES); i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req_i,
    input  logic [WIDTH-1:0] ack_i,
    output logic [WIDTH-1:0] pend_o
);
    logic [WIDTH-1:0] pend_q;

    for (genvar g = 0; g < int'(WIDTH); g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
            end else if (ack_i[g]) begin
                pend_q[g] <= 1'b0;
            end else if (req_i[g]) begin
                pend_q[g] <= 1'b1;
            end
        end
    end

    assign pend_o = pend_q;

    // R4
    ack_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i != '0) |=> ((pend_q & $past(ack_i)) == '0));

    // R2
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~ack_i) != '0) |=> (((($past(pend_q) & ~$past(ack_i))) & ~pend_q) == '0));

    // R5
    req_sets_chk: assert property (@(posedge clk) disable iff (rst)
        ((req_i & ~ack_i) != '0) |=> (((($past(req_i) & ~$past(ack_i))) & ~pend_q) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_collector_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_op_t            op_i,
    input  logic [NUM_SRC-1:0] status_i,
    output logic [NUM_SRC-1:0] ack_o,
    output logic [NUM_SRC-1:0] hide_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rvalid_o
);
    logic [NUM_SRC-1:0] ack_q;
    logic [NUM_SRC-1:0] hide_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               rvalid_q;
    logic [DATA_W-1:0]  rd_word;

    function automatic logic [DATA_W-1:0] widen(input logic [NUM_SRC-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[NUM_SRC-1:0] = v;
        return w;
    endfunction

    always_comb begin
        case (op_i.sel)
            SEL_ACK:    rd_word = widen(ack_q);
            SEL_HIDE:   rd_word = widen(hide_q);
            SEL_STATUS: rd_word = widen(status_i);
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= '0;
            hide_q <= '1;
        end else if (op_i.wr) begin
            if (op_i.sel == SEL_ACK)  ack_q  <= op_i.data[NUM_SRC-1:0];
            if (op_i.sel == SEL_HIDE) hide_q <= op_i.data[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= op_i.rd;
            rdata_q  <= op_i.rd ? rd_word : '0;
        end
    end

    assign ack_o    = ack_q;
    assign hide_o   = hide_q;
    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    // R9
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid_q |-> $past(op_i.rd));

    // R9
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rvalid_q |-> (rdata_q == '0));

    // R3
    hide_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i.wr && op_i.sel == SEL_HIDE) |=> (hide_q == $past(op_i.data[NUM_SRC-1:0])));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i.sel == SEL_NONE) |=> ($stable(hide_q) && $stable(ack_q)));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
    import irq_collector_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rvalid_o,
    output logic               irq_o
);
    bus_op_t            op;
    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack;
    logic [NUM_SRC-1:0] hide;
    logic [NUM_SRC-1:0] status;
    logic               irq_q;

    always_comb begin
        op.wr   = wr_en_i;
        op.rd   = rd_en_i;
        op.sel  = decode_ofs(addr_i);
        op.data = wdata_i;
    end

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    irq_pend #(.WIDTH(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .req_i  (src_sync),
        .ack_i  (ack),
        .pend_o (pend)
    );

    assign status = pend & ~hide;

    irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .status_i (status),
        .ack_o    (ack),
        .hide_o   (hide),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |status;
    end

    assign irq_o = irq_q;

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (status != '0) |=> irq_o);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |=> !irq_o);

    // R3
    hidden_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~hide) == '0) |=> !irq_o);
endmodule

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
    import irq_collector_pkg::*;

    localparam int N    = 32;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        rvalid_o;
    logic        irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    irq_collector #(.NUM_SRC(N), .SYNC_STAGES(SYNC)) u_irq_collector (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o),
        .irq_o    (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on each rising edge
    logic [31:0] m_pend, m_hide, m_ack, m_rd;
    logic        m_irq, m_rv;
    logic [31:0] dly_q[$];

    always @(posedge clk) begin
        logic [31:0] seen, st;
        if (rst) begin
            m_pend = '0; m_hide = '1; m_ack = '0; m_rd = '0;
            m_irq = 1'b0; m_rv = 1'b0;
            dly_q = {};
            for (int i = 0; i < SYNC; i++) dly_q.push_back(32'h0);
        end else begin
            seen = dly_q.pop_front();
            dly_q.push_back(src_i);
            st = m_pend & ~m_hide;
            m_irq = (st != 0);
            m_rv = rd_en_i;
            if (!rd_en_i)                m_rd = '0;
            else if (addr_i == 8'h10)    m_rd = m_ack;
            else if (addr_i == 8'h14)    m_rd = m_hide;
            else if (addr_i == 8'h1C)    m_rd = st;
            else                         m_rd = '0;
            m_pend = (m_pend | seen) & ~m_ack;
            if (wr_en_i) begin
                if (addr_i == 8'h10) m_ack  = wdata_i;
                if (addr_i == 8'h14) m_hide = wdata_i;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 irq_o vs model", {31'b0, irq_o}, {31'b0, m_irq});
            check("R9 rvalid_o vs model", {31'b0, rvalid_o}, {31'b0, m_rv});
            check("R9 rdata_o vs model", rdata_o, m_rd);
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0; addr_i = '0;
        check(tag, rdata_o, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq_o after reset", {31'b0, irq_o}, 32'h0);
        bus_rd(8'h14, 32'hFFFF_FFFF, "R1 mask after reset");
        bus_rd(8'h10, 32'h0, "R1 clear after reset");
        bus_rd(8'h1C, 32'h0, "R1 status after reset");

        // R2 one-cycle pulse on source 3 while masked; R3 masked hides it
        @(negedge clk); src_i = 32'h8;
        @(negedge clk); src_i = 32'h0;
        idle(4);
        bus_rd(8'h1C, 32'h0, "R3 masked source absent from status");
        check("R3 masked source keeps irq_o low", {31'b0, irq_o}, 32'h0);

        // R3 unmask; R2/R6 latched bit now visible
        bus_wr(8'h14, 32'hFFFF_FFF7);
        bus_rd(8'h14, 32'hFFFF_FFF7, "R3 mask readback");
        bus_rd(8'h1C, 32'h0000_0008, "R2 pulse latched and shown R6");
        check("R7 irq_o high with status", {31'b0, irq_o}, 32'h1);

        // R4 acknowledge bit 3
        bus_wr(8'h10, 32'h8);
        bus_rd(8'h10, 32'h8, "R4 clear readback");
        bus_rd(8'h1C, 32'h0, "R4 held clear drops pending");
        bus_wr(8'h10, 32'h0);
        idle(1);
        bus_rd(8'h1C, 32'h0, "R5 no re-pend with source low");
        check("R7 irq_o low after ack", {31'b0, irq_o}, 32'h0);

        // R10 latency on source 0
        bus_wr(8'h14, 32'hFFFF_FFF6);
        idle(1);
        src_i = 32'h1;
        idle(3);
        check("R10 irq_o still low after edge k+2", {31'b0, irq_o}, 32'h0);
        idle(1);
        check("R10 irq_o high after edge k+3", {31'b0, irq_o}, 32'h1);

        // R4/R5 held clear with source still high, then release
        bus_wr(8'h10, 32'h1);
        idle(2);
        bus_rd(8'h1C, 32'h0, "R4 pending zero while clear held, source high");
        bus_wr(8'h10, 32'h0);
        idle(1);
        bus_rd(8'h1C, 32'h1, "R5 re-pend after clear released");

        // R6 bit 0, 5, 31 together, all unmasked
        bus_wr(8'h14, 32'h0);
        @(negedge clk); src_i = 32'h8000_0021;
        idle(4);
        bus_rd(8'h1C, 32'h8000_0021, "R6 status bits 0 5 31");

        // R3 mask keeps pending, irq_o drops, unmask restores
        bus_wr(8'h14, 32'hFFFF_FFFF);
        idle(1);
        check("R3 irq_o low when all masked", {31'b0, irq_o}, 32'h0);
        bus_rd(8'h1C, 32'h0, "R3 status zero when all masked");
        bus_wr(8'h14, 32'h7FFF_FFFF);
        bus_rd(8'h1C, 32'h8000_0000, "R6 only bit 31 unmasked");

        // R8 unmapped offsets
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h18, 32'h0, "R8 unmapped read 0x18");
        bus_rd(8'h00, 32'h0, "R8 unmapped read 0x00");
        bus_rd(8'h14, 32'h7FFF_FFFF, "R8 mask unchanged by unmapped write");
        bus_rd(8'h10, 32'h0, "R8 clear unchanged by unmapped write");

        // R9 rvalid is a single-cycle pulse
        @(negedge clk); rd_en_i = 1'b1; addr_i = 8'h14;
        @(negedge clk); rd_en_i = 1'b0; addr_i = '0;
        check("R9 rvalid high after strobe", {31'b0, rvalid_o}, 32'h1);
        @(negedge clk);
        check("R9 rvalid low next cycle", {31'b0, rvalid_o}, 32'h0);
        check("R9 rdata zero when idle", rdata_o, 32'h0);

        // Drain: drop sources, acknowledge all
        @(negedge clk); src_i = 32'h0;
        idle(3);
        bus_wr(8'h10, 32'hFFFF_FFFF);
        idle(1);
        bus_wr(8'h10, 32'h0);
        bus_wr(8'h14, 32'h0);
        idle(2);
        bus_rd(8'h1C, 32'h0, "R4 all acknowledged");
        check("R7 irq_o low at end", {31'b0, irq_o}, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule